// File: doc/BRIEF.md
# Pause Flow-Control Resolver

This block settles which direction of pause flow control a link uses once auto-negotiation has finished. It compares the symmetric and asymmetric pause abilities advertised by the local side and by the link partner. It also takes the requested mode, a strict-standard flag, the media kind (copper or serdes) and the duplex. From these it produces registered receive-pause and transmit-pause enables. It also produces the receive FIFO low and high watermarks. Those are non-zero only when the link may send pause frames, and the low one carries an XON-enable flag.

A control agent presents its inputs and pulses `resolve_i` for one cycle. The outputs take their new values at the following clock edge and then hold until the next strobe. The requested mode may name a fixed mode directly. It may also select the auto setting, in which case the mode comes from the two pause bits of a configuration word. A request code outside the defined set raises `cfg_err_o` and changes nothing else.

Top module: `pause_resolve`

## Requirements
- R1: While `rst_ni` is low, every output is zero: mode none, both enables off, both watermarks zero, `cfg_err_o` clear.
- R2: `mode_o` encodes 0 = none, 1 = receive only, 2 = transmit only, 3 = full. `rx_pause_o` equals `mode_o[0]` and `tx_pause_o` equals `mode_o[1]`.
- R3: When both sides advertise symmetric pause, the result is full if the effective request is full, and receive only for any other request.
- R4: When the local side advertises asymmetric pause without symmetric pause, and the partner advertises both, the result is transmit only.
- R5: When the local side advertises both, and the partner advertises asymmetric pause without symmetric pause, the result is receive only.
- R6: Any other combination on copper (`serdes_i`=0) resolves to none if the effective request is none or transmit only, or if `strict_i` is set. Otherwise it resolves to receive only. On serdes any other combination resolves to none.
- R7: On copper, a half-duplex link (`full_duplex_i`=0) forces the result to none. On serdes the duplex input has no effect.
- R8: A strobe with `an_done_i` low leaves the mode, the enables and the watermarks unchanged.
- R9: When the resolved mode is transmit only or full, `high_wm_o` equals `high_water_i` and `low_wm_o` equals `{send_xon_i, low_water_i}`, with the flag in the most significant bit. Otherwise both watermarks are zero.
- R10: Request code 4 (auto) takes the request from `cfg_pause_i`, where bit 0 is symmetric and bit 1 is asymmetric. 00 gives none, 10 gives transmit only, and 01 or 11 gives full. Codes 0 to 3 request the mode of the same number.
- R11: On a strobe with request code 5, 6 or 7, `cfg_err_o` is 1 on the next cycle and the mode, enables and watermarks are unchanged. A strobe with a valid code clears `cfg_err_o`.
- R12: The outputs change only on the clock edge that samples `resolve_i` high. Without a strobe they hold, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| resolve_i | input | 1 | One-cycle strobe to resolve and update |
| an_done_i | input | 1 | Auto-negotiation has completed |
| loc_sym_i | input | 1 | Local symmetric pause advertised |
| loc_asym_i | input | 1 | Local asymmetric pause advertised |
| lp_sym_i | input | 1 | Partner symmetric pause advertised |
| lp_asym_i | input | 1 | Partner asymmetric pause advertised |
| req_mode_i | input | 3 | Requested mode: 0-3 fixed, 4 auto, 5-7 invalid |
| cfg_pause_i | input | 2 | Pause bits of the configuration word (bit0 symmetric, bit1 asymmetric) |
| strict_i | input | 1 | Strict-standard fallback on copper |
| serdes_i | input | 1 | Media is serdes (1) or copper (0) |
| full_duplex_i | input | 1 | Link is full duplex |
| send_xon_i | input | 1 | XON sending configured |
| low_water_i | input | WM_W | Low watermark value |
| high_water_i | input | WM_W | High watermark value |
| mode_o | output | 2 | Resolved mode |
| rx_pause_o | output | 1 | Honour received pause frames |
| tx_pause_o | output | 1 | Allow sending pause frames |
| low_wm_o | output | WM_W+1 | XON flag and low watermark |
| high_wm_o | output | WM_W | High watermark |
| cfg_err_o | output | 1 | Last strobe carried an invalid request code |

## Verification
The outputs are registered, so a bad entry in the negotiation table shows on `mode_o` and on the enables at the first edge after the strobe that hits that input combination. No later cycle is needed. If the watermark gate goes out of step with the mode, a watermark is non-zero while `tx_pause_o` is low, and that is visible in the same cycle. A faulty hold or update path shows as an output that moves without a strobe, or that keeps an old value after a valid strobe with negotiation complete. The scoreboard catches either case one cycle after the strobe.

// File: rtl/pause_pkg.sv
package pause_pkg;
  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_RX   = 2'd1,
    PM_TX   = 2'd2,
    PM_FULL = 2'd3
  } pmode_e;

  localparam logic [2:0] REQ_AUTO = 3'd4;

  function automatic logic rx_en(pmode_e m);
    return (m == PM_RX) || (m == PM_FULL);
  endfunction

  function automatic logic tx_en(pmode_e m);
    return (m == PM_TX) || (m == PM_FULL);
  endfunction
endpackage

// File: rtl/pause_req_decode.sv
module pause_req_decode
  import pause_pkg::*;
(
  input  logic [2:0] req_i,
  input  logic [1:0] cfg_pause_i,
  output pmode_e     eff_o,
  output logic       ok_o
);
  always_comb begin
    ok_o  = 1'b1;
    eff_o = PM_NONE;
    if (req_i < REQ_AUTO) begin
      eff_o = pmode_e'(req_i[1:0]);
    end else if (req_i == REQ_AUTO) begin
      // bit0 symmetric, bit1 asymmetric
      case (cfg_pause_i)
        2'b00:   eff_o = PM_NONE;
        2'b10:   eff_o = PM_TX;
        default: eff_o = PM_FULL;
      endcase
    end else begin
      ok_o = 1'b0;
    end
  end
endmodule

// File: rtl/pause_negotiate.sv
module pause_negotiate
  import pause_pkg::*;
(
  input  logic   loc_sym_i,
  input  logic   loc_asym_i,
  input  logic   lp_sym_i,
  input  logic   lp_asym_i,
  input  pmode_e req_i,
  input  logic   strict_i,
  input  logic   serdes_i,
  input  logic   full_duplex_i,
  output pmode_e mode_o
);
  pmode_e table_mode;

  always_comb begin
    if (loc_sym_i && lp_sym_i) begin
      table_mode = (req_i == PM_FULL) ? PM_FULL : PM_RX;
    end else if (!loc_sym_i && loc_asym_i && lp_sym_i && lp_asym_i) begin
      table_mode = PM_TX;
    end else if (loc_sym_i && loc_asym_i && !lp_sym_i && lp_asym_i) begin
      table_mode = PM_RX;
    end else if (serdes_i) begin
      table_mode = PM_NONE;
    end else if (req_i == PM_NONE || req_i == PM_TX || strict_i) begin
      table_mode = PM_NONE;
    end else begin
      table_mode = PM_RX;
    end
  end

  // half duplex kills pause on copper only
  assign mode_o = (!serdes_i && !full_duplex_i) ? PM_NONE : table_mode;
endmodule

// File: rtl/pause_wm_gen.sv
module pause_wm_gen
  import pause_pkg::*;
#(
  parameter int WM_W = 16
) (
  input  pause_pkg::pmode_e mode_i,
  input  logic              send_xon_i,
  input  logic [WM_W-1:0]   low_i,
  input  logic [WM_W-1:0]   high_i,
  output logic [WM_W:0]     low_o,
  output logic [WM_W-1:0]   high_o
);
  localparam int LOW_W = WM_W + 1;
  logic gate;

  assign gate = tx_en(mode_i);

  always_comb begin
    low_o  = '0;
    high_o = '0;
    if (gate) begin
      low_o  = LOW_W'({send_xon_i, low_i});
      high_o = high_i;
    end
  end
endmodule

// File: rtl/pause_resolve.sv
module pause_resolve
  import pause_pkg::*;
#(
  parameter int WM_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            resolve_i,
  input  logic            an_done_i,
  input  logic            loc_sym_i,
  input  logic            loc_asym_i,
  input  logic            lp_sym_i,
  input  logic            lp_asym_i,
  input  logic [2:0]      req_mode_i,
  input  logic [1:0]      cfg_pause_i,
  input  logic            strict_i,
  input  logic            serdes_i,
  input  logic            full_duplex_i,
  input  logic            send_xon_i,
  input  logic [WM_W-1:0] low_water_i,
  input  logic [WM_W-1:0] high_water_i,
  output logic [1:0]      mode_o,
  output logic            rx_pause_o,
  output logic            tx_pause_o,
  output logic [WM_W:0]   low_wm_o,
  output logic [WM_W-1:0] high_wm_o,
  output logic            cfg_err_o
);
  pmode_e          eff_req, res_mode, mode_q;
  logic            req_ok;
  logic [WM_W:0]   low_d, low_q;
  logic [WM_W-1:0] high_d, high_q;
  logic            rx_q, tx_q, err_q;

  pause_req_decode u_dec (
    .req_i       (req_mode_i),
    .cfg_pause_i (cfg_pause_i),
    .eff_o       (eff_req),
    .ok_o        (req_ok)
  );

  pause_negotiate u_neg (
    .loc_sym_i     (loc_sym_i),
    .loc_asym_i    (loc_asym_i),
    .lp_sym_i      (lp_sym_i),
    .lp_asym_i     (lp_asym_i),
    .req_i         (eff_req),
    .strict_i      (strict_i),
    .serdes_i      (serdes_i),
    .full_duplex_i (full_duplex_i),
    .mode_o        (res_mode)
  );

  pause_wm_gen #(.WM_W(WM_W)) u_wm (
    .mode_i     (res_mode),
    .send_xon_i (send_xon_i),
    .low_i      (low_water_i),
    .high_i     (high_water_i),
    .low_o      (low_d),
    .high_o     (high_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_NONE;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
      low_q  <= '0;
      high_q <= '0;
      err_q  <= 1'b0;
    end else if (resolve_i) begin
      err_q <= !req_ok;
      if (an_done_i && req_ok) begin
        mode_q <= res_mode;
        rx_q   <= rx_en(res_mode);
        tx_q   <= tx_en(res_mode);
        low_q  <= low_d;
        high_q <= high_d;
      end
    end
  end

  assign mode_o     = mode_q;
  assign rx_pause_o = rx_q;
  assign tx_pause_o = tx_q;
  assign low_wm_o   = low_q;
  assign high_wm_o  = high_q;
  assign cfg_err_o  = err_q;
endmodule

// File: rtl/pause_resolve_chk.sv
module pause_resolve_chk #(
  parameter int WM_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            resolve_i,
  input logic            an_done_i,
  input logic [2:0]      req_mode_i,
  input logic            serdes_i,
  input logic            full_duplex_i,
  input logic [1:0]      mode_o,
  input logic            rx_pause_o,
  input logic            tx_pause_o,
  input logic [WM_W:0]   low_wm_o,
  input logic [WM_W-1:0] high_wm_o,
  input logic            cfg_err_o
);
  a_r2_rx_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pause_o == mode_o[0]);

  a_r2_tx_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pause_o == mode_o[1]);

  a_r9_wm_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_pause_o |-> (low_wm_o == '0) && (high_wm_o == '0));

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resolve_i |=> $stable(mode_o) && $stable(low_wm_o) && $stable(high_wm_o)
                   && $stable(cfg_err_o));

  a_r8_an_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && !an_done_i) |=> $stable(mode_o) && $stable(low_wm_o)
                                  && $stable(high_wm_o));

  a_r11_bad_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && req_mode_i > 3'd4) |=> cfg_err_o && $stable(mode_o));

  a_r7_half_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && an_done_i && req_mode_i <= 3'd4 && !serdes_i && !full_duplex_i)
      |=> mode_o == 2'b00);
endmodule

bind pause_resolve pause_resolve_chk #(.WM_W(WM_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .resolve_i     (resolve_i),
  .an_done_i     (an_done_i),
  .req_mode_i    (req_mode_i),
  .serdes_i      (serdes_i),
  .full_duplex_i (full_duplex_i),
  .mode_o        (mode_o),
  .rx_pause_o    (rx_pause_o),
  .tx_pause_o    (tx_pause_o),
  .low_wm_o      (low_wm_o),
  .high_wm_o     (high_wm_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/tb_pause_resolve.sv
`timescale 1ns/1ps
module tb_pause_resolve;
  localparam int WM_W = 16;
  localparam int OW = 2 + 1 + (WM_W + 1) + WM_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic resolve_i = 0, an_done_i = 0, loc_sym_i = 0, loc_asym_i = 0;
  logic lp_sym_i = 0, lp_asym_i = 0, strict_i = 0, serdes_i = 0;
  logic full_duplex_i = 0, send_xon_i = 0;
  logic [2:0] req_mode_i = '0;
  logic [1:0] cfg_pause_i = '0;
  logic [WM_W-1:0] low_water_i = '0, high_water_i = '0;
  logic [1:0] mode_o;
  logic rx_pause_o, tx_pause_o, cfg_err_o;
  logic [WM_W:0] low_wm_o;
  logic [WM_W-1:0] high_wm_o;

  int checks = 0;
  int errs = 0;
  logic fire_q = 1'b0;

  logic [OW-1:0] exp_q[$];
  string tag_q[$];

  logic [1:0] m_mode = 2'd0;
  logic m_err = 1'b0;
  logic [WM_W:0] m_lw = '0;
  logic [WM_W-1:0] m_hw = '0;

  always #4 clk_i = ~clk_i;

  pause_resolve #(.WM_W(WM_W)) dut (.*);

  always @(posedge clk_i) fire_q <= resolve_i;

  function automatic logic [OW-1:0] actual();
    return {mode_o, cfg_err_o, low_wm_o, high_wm_o};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one cycle after each strobe
  always @(negedge clk_i) begin
    if (fire_q && exp_q.size() > 0) begin
      logic [OW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(actual() === e, t, actual(), e);
      check(rx_pause_o === e[OW-2] && tx_pause_o === e[OW-1],
            {t, " R2 enables"}, {rx_pause_o, tx_pause_o}, e[OW-1 -: 2]);
    end
  end

  function automatic logic [1:0] ref_mode(logic ls, la, ps, pa, logic [1:0] rq,
                                           logic st, sd, fd);
    logic [1:0] r;
    if (ls && ps) r = (rq == 2'd3) ? 2'd3 : 2'd1;
    else if (!ls && la && ps && pa) r = 2'd2;
    else if (ls && la && !ps && pa) r = 2'd1;
    else if (sd) r = 2'd0;
    else if (rq == 2'd0 || rq == 2'd2 || st) r = 2'd0;
    else r = 2'd1;
    if (!sd && !fd) r = 2'd0;
    return r;
  endfunction

  task automatic drive(input logic ls, la, ps, pa, input logic [2:0] rq,
                       input logic [1:0] cfg, input logic st, sd, fd, an, xon,
                       input string tag);
    logic [1:0] eff;
    bit ok;
    ok = (rq <= 3'd4);
    if (rq < 3'd4) eff = rq[1:0];
    else eff = (cfg == 2'b00) ? 2'd0 : (cfg == 2'b10) ? 2'd2 : 2'd3;
    m_err = !ok;
    if (ok && an) begin
      m_mode = ref_mode(ls, la, ps, pa, eff, st, sd, fd);
      if (m_mode[1]) begin
        m_lw = {xon, 16'h0120};
        m_hw = 16'h0340;
      end else begin
        m_lw = '0;
        m_hw = '0;
      end
    end
    exp_q.push_back({m_mode, m_err, m_lw, m_hw});
    tag_q.push_back(tag);
    @(negedge clk_i);
    loc_sym_i = ls; loc_asym_i = la; lp_sym_i = ps; lp_asym_i = pa;
    req_mode_i = rq; cfg_pause_i = cfg; strict_i = st; serdes_i = sd;
    full_duplex_i = fd; an_done_i = an; send_xon_i = xon;
    low_water_i = 16'h0120; high_water_i = 16'h0340;
    resolve_i = 1'b1;
    @(negedge clk_i);
    resolve_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 20000);
    errs++;
    checks++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(actual() === '0 && !rx_pause_o && !tx_pause_o, "R1 reset",
          actual(), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    //     ls la ps pa req    cfg  st sd fd an xon
    drive(1, 0, 1, 0, 3'd3, 2'b00, 0, 0, 1, 1, 1, "R3 both sym full req -> full, R9 wm");
    drive(1, 0, 1, 0, 3'd0, 2'b00, 0, 0, 1, 1, 1, "R3 both sym none req -> rx, R9 wm zero");
    drive(0, 1, 1, 1, 3'd0, 2'b00, 0, 0, 1, 1, 1, "R4 asym local -> tx, R9 xon");
    drive(0, 1, 1, 1, 3'd1, 2'b00, 0, 0, 1, 1, 0, "R4 asym local -> tx, R9 no xon");
    drive(1, 1, 0, 1, 3'd3, 2'b00, 0, 0, 1, 1, 1, "R5 asym partner -> rx");
    drive(0, 0, 0, 0, 3'd3, 2'b00, 0, 0, 1, 1, 1, "R6 copper fallback full -> rx");
    drive(0, 0, 0, 0, 3'd3, 2'b00, 1, 0, 1, 1, 1, "R6 copper fallback strict -> none");
    drive(0, 1, 0, 1, 3'd2, 2'b00, 0, 0, 1, 1, 1, "R6 copper fallback tx req -> none");
    drive(0, 0, 0, 0, 3'd3, 2'b00, 0, 1, 1, 1, 1, "R6 serdes fallback -> none");
    drive(1, 0, 1, 0, 3'd3, 2'b00, 0, 0, 0, 1, 1, "R7 copper half duplex -> none");
    drive(1, 0, 1, 0, 3'd3, 2'b00, 0, 1, 0, 1, 1, "R7 serdes half duplex ignored -> full");
    drive(0, 0, 0, 0, 3'd3, 2'b00, 1, 0, 1, 0, 0, "R8 no autoneg keeps outputs");
    drive(0, 0, 0, 0, 3'd6, 2'b00, 1, 0, 1, 1, 0, "R11 invalid req sets err, holds");
    drive(0, 1, 1, 1, 3'd7, 2'b00, 0, 0, 1, 1, 0, "R11 invalid req 7 holds");
    drive(0, 1, 1, 1, 3'd1, 2'b00, 0, 0, 1, 1, 0, "R11 valid req clears err");
    drive(1, 0, 1, 0, 3'd4, 2'b00, 0, 0, 1, 1, 1, "R10 auto cfg 00 -> none req -> rx");
    drive(1, 0, 1, 0, 3'd4, 2'b10, 0, 0, 1, 1, 1, "R10 auto cfg 10 -> tx req -> rx");
    drive(1, 0, 1, 0, 3'd4, 2'b01, 0, 0, 1, 1, 1, "R10 auto cfg 01 -> full");
    drive(0, 0, 0, 0, 3'd4, 2'b11, 0, 0, 1, 1, 0, "R10 auto cfg 11 -> full req fallback rx");
    drive(1, 0, 1, 0, 3'd3, 2'b00, 0, 0, 1, 1, 1, "R3 restore full");
    // R12: inputs move with no strobe
    @(negedge clk_i);
    req_mode_i = 3'd0; full_duplex_i = 0; serdes_i = 0; an_done_i = 1;
    loc_sym_i = 0; lp_sym_i = 0; send_xon_i = 0;
    repeat (3) @(negedge clk_i);
    check(actual() === {m_mode, m_err, m_lw, m_hw}, "R12 hold without strobe",
          actual(), {m_mode, m_err, m_lw, m_hw});
    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      errs++;
      checks++;
      $display("FAIL R12 scoreboard not drained actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule